// File: doc/BRIEF.md
# Five-by-Four Bus Crossbar with Per-Slave Round-Robin Arbitration

This block joins several bus masters to several bus slaves so that every master can reach every slave. Each master offers a request, a 32-bit address, a write strobe, 64 bits of write data and a flag that marks the final beat of its transaction. The two most significant address bits pick the target slave. Each slave port has its own arbiter. The arbiter chooses one of the masters that want that slave and forwards that master's address, write data, write strobe and final-beat flag. It then passes the slave's ready and read data back to that master only.

Arbitration is fair. No master has priority, and each slave rotates its grant, starting the search at the master that follows the one it granted last. Once granted, a master keeps the slave until its final beat is accepted or it drops its request. Other masters that want the same slave wait with ready low. Masters that target different slaves are served in the same cycle, independently of each other.

Top module: `xbar_matrix`

## Requirements
- R1: Address bits [31:30] of a master select the target slave: value 0 selects slave 0 and value 3 selects slave 3. A master is only ever connected to the slave its address selects.
- R2: A slave port with no requesting master drives its request output low, and no master sees ready from it.
- R3: When several masters want the same free slave, exactly one is granted. The winner is the first requesting master found by searching upward from (last granted ID + 1), wrapping from master 4 to master 0. After reset the search behaves as if master 4 was granted last, so master 0 wins first.
- R4: A granted master keeps the slave while its request stays high and its final beat has not been accepted. During that time every other master that wants this slave sees ready low.
- R5: Ownership ends in the cycle in which the slave accepts the final beat (slave ready high and final-beat flag high). The next cycle may grant any requesting master by the round-robin rule.
- R6: Masters that target different slaves are granted and completed in the same cycle.
- R7: A master's ready is high only when it holds the grant of its target slave and that slave's ready is high. A master's read data equals its slave's read data while it holds the grant and is zero otherwise.
- R8: A slave port forwards the address, write strobe, write data and final-beat flag of its owning master unchanged.
- R9: Each slave keeps a 3-bit record of the master ID it granted last. The record changes only when a new grant is issued, so idle cycles and held cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 5 | Per-master transfer request |
| m_addr | input | 160 | Master addresses, master i at bits [32i+31:32i] |
| m_we | input | 5 | Per-master write strobe |
| m_wdata | input | 320 | Master write data, master i at bits [64i+63:64i] |
| m_last | input | 5 | Per-master final-beat flag |
| m_ready | output | 5 | Per-master beat accepted |
| m_rdata | output | 320 | Read data returned to each master |
| s_req | output | 4 | Per-slave request from the owning master |
| s_addr | output | 128 | Forwarded address, slave j at bits [32j+31:32j] |
| s_we | output | 4 | Forwarded write strobe |
| s_wdata | output | 256 | Forwarded write data, slave j at bits [64j+63:64j] |
| s_last | output | 4 | Forwarded final-beat flag |
| s_ready | input | 4 | Per-slave beat accepted |
| s_rdata | input | 256 | Per-slave read data |

## Verification
Some checks run on every cycle. Each slave grants at most one master, and only a master that is requesting. A master appears in at most one slave's grant. An unfinished owner keeps its grant into the next cycle. The last-granted record stays put whenever no new grant is issued. An idle slave keeps its request low, and a master's ready never appears without its request. Which master wins at each contention point, the wrap from master 4 to master 0, the release on the final beat and the regrant in the next cycle, the parallel service of all four slaves, and the restart of rotation after reset all depend on a sequence of earlier grants, so only the bench's scenarios show them.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

   localparam int XB_ADDR_W = 32;
   localparam int XB_DATA_W = 64;
   localparam int XB_MASTERS = 5;
   localparam int XB_SLAVES = 4;

   // Width of an index that can name n items, never below one bit.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/xbar_addr_dec.sv
module xbar_addr_dec #(
   parameter int ADDR_W = xbar_pkg::XB_ADDR_W,
   parameter int N_SLV  = xbar_pkg::XB_SLAVES,
   parameter int SEL_W  = xbar_pkg::idx_width(N_SLV)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [SEL_W-1:0]  sel
);
   localparam int SEL_LSB = ADDR_W - SEL_W;

   initial begin
      assert (SEL_W <= ADDR_W) else $error("xbar_addr_dec: select wider than address");
   end

   generate
      if (N_SLV == 1) begin : g_single
         assign sel = '0;
      end else begin : g_slice
         assign sel = addr[ADDR_W-1:SEL_LSB];
      end
   endgenerate

endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
   parameter int N_MST = xbar_pkg::XB_MASTERS,
   parameter int ID_W  = xbar_pkg::idx_width(N_MST)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_MST-1:0] req,
   input  logic             done,
   output logic [N_MST-1:0] gnt,
   output logic             gnt_valid,
   output logic [ID_W-1:0]  gnt_id
);
   localparam logic [ID_W-1:0] RESET_LAST = ID_W'(N_MST - 1);

   logic            own_q;
   logic [ID_W-1:0] own_id_q;
   logic [ID_W-1:0] last_q;
   logic [ID_W-1:0] pick_id;
   logic            any_req;
   logic            new_grant;

   initial begin
      assert (N_MST >= 2) else $error("xbar_rr_arb: needs at least two masters");
      assert ((1 << ID_W) >= N_MST) else $error("xbar_rr_arb: ID width too small");
   end

   assign any_req = |req;

   // Search upward from the master after the last one granted.
   always_comb begin
      pick_id = last_q;
      for (int k = N_MST; k >= 1; k--) begin
         int c;
         c = int'(last_q) + k;
         if (c >= N_MST) c = c - N_MST;
         if (req[c]) pick_id = ID_W'(c);
      end
   end

   always_comb begin
      if (own_q) begin
         gnt_id    = own_id_q;
         gnt_valid = req[own_id_q];
      end else begin
         gnt_id    = pick_id;
         gnt_valid = any_req;
      end
      gnt = '0;
      if (gnt_valid) gnt[gnt_id] = 1'b1;
   end

   assign new_grant = !own_q && any_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q    <= 1'b0;
         own_id_q <= '0;
         last_q   <= RESET_LAST;
      end else if (own_q) begin
         if (!req[own_id_q] || done) own_q <= 1'b0;
      end else if (new_grant) begin
         last_q   <= pick_id;
         own_id_q <= pick_id;
         own_q    <= !done;
      end
   end

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R3
   AST_GNT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n) ((gnt & ~req) == '0)); // R3
   AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && !done) |=> (((gnt & $past(gnt)) != '0) || ((req & $past(gnt)) == '0))); // R4
   AST_LAST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q || !any_req) |=> $stable(last_q)); // R9

endmodule

// File: rtl/xbar_slave_mux.sv
module xbar_slave_mux #(
   parameter int N_MST  = xbar_pkg::XB_MASTERS,
   parameter int ADDR_W = xbar_pkg::XB_ADDR_W,
   parameter int DATA_W = xbar_pkg::XB_DATA_W,
   parameter int ID_W   = xbar_pkg::idx_width(N_MST)
) (
   input  logic                    gnt_valid,
   input  logic [ID_W-1:0]         gnt_id,
   input  logic [N_MST*ADDR_W-1:0] m_addr,
   input  logic [N_MST-1:0]        m_we,
   input  logic [N_MST*DATA_W-1:0] m_wdata,
   input  logic [N_MST-1:0]        m_last,
   output logic                    s_req,
   output logic [ADDR_W-1:0]       s_addr,
   output logic                    s_we,
   output logic [DATA_W-1:0]       s_wdata,
   output logic                    s_last
);
   always_comb begin
      s_req   = gnt_valid;
      s_addr  = '0;
      s_we    = 1'b0;
      s_wdata = '0;
      s_last  = 1'b0;
      for (int i = 0; i < N_MST; i++) begin
         if (gnt_valid && (gnt_id == ID_W'(i))) begin
            s_addr  = m_addr[i*ADDR_W +: ADDR_W];
            s_we    = m_we[i];
            s_wdata = m_wdata[i*DATA_W +: DATA_W];
            s_last  = m_last[i];
         end
      end
   end

endmodule

// File: rtl/xbar_matrix.sv
module xbar_matrix #(
   parameter int N_MST  = xbar_pkg::XB_MASTERS,
   parameter int N_SLV  = xbar_pkg::XB_SLAVES,
   parameter int ADDR_W = xbar_pkg::XB_ADDR_W,
   parameter int DATA_W = xbar_pkg::XB_DATA_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_MST-1:0]        m_req,
   input  logic [N_MST*ADDR_W-1:0] m_addr,
   input  logic [N_MST-1:0]        m_we,
   input  logic [N_MST*DATA_W-1:0] m_wdata,
   input  logic [N_MST-1:0]        m_last,
   output logic [N_MST-1:0]        m_ready,
   output logic [N_MST*DATA_W-1:0] m_rdata,
   output logic [N_SLV-1:0]        s_req,
   output logic [N_SLV*ADDR_W-1:0] s_addr,
   output logic [N_SLV-1:0]        s_we,
   output logic [N_SLV*DATA_W-1:0] s_wdata,
   output logic [N_SLV-1:0]        s_last,
   input  logic [N_SLV-1:0]        s_ready,
   input  logic [N_SLV*DATA_W-1:0] s_rdata
);
   localparam int SEL_W = xbar_pkg::idx_width(N_SLV);
   localparam int ID_W  = xbar_pkg::idx_width(N_MST);

   initial begin
      assert (N_SLV == (1 << SEL_W) || N_SLV == 1) else $error("xbar_matrix: slave count must be a power of two");
      assert (ADDR_W > SEL_W) else $error("xbar_matrix: address too narrow");
      assert (DATA_W >= 8) else $error("xbar_matrix: data path too narrow");
   end

   logic [N_MST-1:0][SEL_W-1:0] msel;
   logic [N_SLV-1:0][N_MST-1:0] req_mat;
   logic [N_SLV-1:0][N_MST-1:0] gnt_mat;
   logic [N_SLV-1:0]            gvalid;
   logic [N_SLV-1:0][ID_W-1:0]  gid;

   // Address decode, one per master.
   for (genvar i = 0; i < N_MST; i++) begin : g_dec
      xbar_addr_dec #(.ADDR_W(ADDR_W), .N_SLV(N_SLV), .SEL_W(SEL_W)) i_dec (
         .addr (m_addr[i*ADDR_W +: ADDR_W]),
         .sel  (msel[i])
      );
   end

   always_comb begin
      for (int j = 0; j < N_SLV; j++) begin
         for (int i = 0; i < N_MST; i++) begin
            req_mat[j][i] = m_req[i] && (msel[i] == SEL_W'(j));
         end
      end
   end

   // One arbiter and one forward multiplexer per slave port.
   for (genvar j = 0; j < N_SLV; j++) begin : g_slv
      logic beat_done;
      assign beat_done = s_req[j] && s_ready[j] && s_last[j];

      xbar_rr_arb #(.N_MST(N_MST), .ID_W(ID_W)) i_arb (
         .clk       (clk),
         .rst_n     (rst_n),
         .req       (req_mat[j]),
         .done      (beat_done),
         .gnt       (gnt_mat[j]),
         .gnt_valid (gvalid[j]),
         .gnt_id    (gid[j])
      );

      xbar_slave_mux #(.N_MST(N_MST), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) i_mux (
         .gnt_valid (gvalid[j]),
         .gnt_id    (gid[j]),
         .m_addr    (m_addr),
         .m_we      (m_we),
         .m_wdata   (m_wdata),
         .m_last    (m_last),
         .s_req     (s_req[j]),
         .s_addr    (s_addr[j*ADDR_W +: ADDR_W]),
         .s_we      (s_we[j]),
         .s_wdata   (s_wdata[j*DATA_W +: DATA_W]),
         .s_last    (s_last[j])
      );

      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (req_mat[j] == '0) |-> !s_req[j]); // R2
   end

   // Response return, one per master.
   for (genvar i = 0; i < N_MST; i++) begin : g_ret
      logic              owns;
      logic [N_SLV-1:0]  col;
      for (genvar j = 0; j < N_SLV; j++) begin : g_col
         assign col[j] = gnt_mat[j][i];
      end
      assign owns       = gnt_mat[msel[i]][i];
      assign m_ready[i] = owns && s_ready[msel[i]];
      assign m_rdata[i*DATA_W +: DATA_W] = owns ? s_rdata[msel[i]*DATA_W +: DATA_W] : '0;

      AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(col) && ((col & ~(N_SLV'(1) << msel[i])) == '0)); // R1
      AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
         m_ready[i] |-> m_req[i]); // R7
   end

endmodule

// File: tb/test_xbar_matrix.sv
module test_xbar_matrix;
   localparam int NM = 5;
   localparam int NS = 4;
   localparam int AW = 32;
   localparam int DW = 64;

   typedef struct packed {
      logic [4:0] req;
      logic [9:0] sel;
      logic [4:0] last;
      logic [3:0] srdy;
      logic [4:0] exp_mrdy;
      logic [3:0] exp_sreq;
   } vec_t;

   // Walked from reset; every slave starts as if master 4 was granted last.
   localparam vec_t VEC [14] = '{
      '{5'b00000, 10'h000, 5'b00000, 4'b0000, 5'b00000, 4'b0000}, // R2 idle
      '{5'b00111, 10'h000, 5'b11111, 4'b0001, 5'b00001, 4'b0001}, // R3 m0 first
      '{5'b00111, 10'h000, 5'b11111, 4'b0001, 5'b00010, 4'b0001}, // R3 m1
      '{5'b00111, 10'h000, 5'b11111, 4'b0001, 5'b00100, 4'b0001}, // R3 m2
      '{5'b00111, 10'h000, 5'b11111, 4'b0001, 5'b00001, 4'b0001}, // R3 wrap to m0
      '{5'b00110, 10'h000, 5'b00000, 4'b0001, 5'b00010, 4'b0001}, // R4 m1 owns
      '{5'b00110, 10'h000, 5'b00000, 4'b0000, 5'b00000, 4'b0001}, // R4 stall
      '{5'b00110, 10'h000, 5'b00010, 4'b0001, 5'b00010, 4'b0001}, // R5 final beat
      '{5'b00110, 10'h000, 5'b11111, 4'b0001, 5'b00100, 4'b0001}, // R5 regrant m2
      '{5'b11111, 10'h0E4, 5'b11111, 4'b1111, 5'b11110, 4'b1111}, // R6 all slaves
      '{5'b00001, 10'h000, 5'b00000, 4'b0000, 5'b00000, 4'b0001}, // R4 m0 owns
      '{5'b01001, 10'h000, 5'b00001, 4'b0001, 5'b00001, 4'b0001}, // R4 m3 waits
      '{5'b00000, 10'h000, 5'b00000, 4'b1111, 5'b00000, 4'b0000}, // R2 idle ready
      '{5'b01010, 10'h000, 5'b11111, 4'b0001, 5'b00010, 4'b0001}  // R9 m1 after m0
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NM-1:0]     m_req = '0;
   logic [NM*AW-1:0]  m_addr = '0;
   logic [NM-1:0]     m_we = 5'b01010;
   logic [NM*DW-1:0]  m_wdata;
   logic [NM-1:0]     m_last = '0;
   logic [NM-1:0]     m_ready;
   logic [NM*DW-1:0]  m_rdata;
   logic [NS-1:0]     s_req;
   logic [NS*AW-1:0]  s_addr;
   logic [NS-1:0]     s_we;
   logic [NS*DW-1:0]  s_wdata;
   logic [NS-1:0]     s_last;
   logic [NS-1:0]     s_ready = '0;
   logic [NS*DW-1:0]  s_rdata;

   int nchk = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   xbar_matrix i_xbar_matrix (
      .clk(clk), .rst_n(rst_n),
      .m_req(m_req), .m_addr(m_addr), .m_we(m_we), .m_wdata(m_wdata), .m_last(m_last),
      .m_ready(m_ready), .m_rdata(m_rdata),
      .s_req(s_req), .s_addr(s_addr), .s_we(s_we), .s_wdata(s_wdata), .s_last(s_last),
      .s_ready(s_ready), .s_rdata(s_rdata)
   );

   initial begin
      for (int i = 0; i < NM; i++) m_wdata[i*DW +: DW] = 64'hD0D0_0000_0000_0000 | 64'(i + 1);
      for (int j = 0; j < NS; j++) s_rdata[j*DW +: DW] = 64'h5100_0000_0000_0000 | 64'(j + 1);
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [4:0] req, input logic [9:0] sel,
                        input logic [4:0] last, input logic [3:0] srdy);
      @(negedge clk);
      m_req = req;
      m_last = last;
      s_ready = srdy;
      for (int i = 0; i < NM; i++) m_addr[i*AW +: AW] = {sel[2*i +: 2], 22'h0, 8'(i * 16)};
      #1;
   endtask

   initial begin
      #(200000 * 8);
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      // Reset state.
      repeat (3) @(posedge clk);
      #1;
      chk("R2 reset s_req", 64'(s_req), 64'h0);
      chk("R2 reset m_ready", 64'(m_ready), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // Vector table.
      for (int v = 0; v < 14; v++) begin
         drive(VEC[v].req, VEC[v].sel, VEC[v].last, VEC[v].srdy);
         chk($sformatf("R3/R4/R5/R6 vec%0d m_ready", v), 64'(m_ready), 64'(VEC[v].exp_mrdy));
         chk($sformatf("R1/R2 vec%0d s_req", v), 64'(s_req), 64'(VEC[v].exp_sreq));
      end

      // R8 and R7: m2 and m4 to slave 2; slave 2 last granted m2, so m4 wins.
      drive(5'b10100, 10'h220, 5'b11111, 4'b0100);
      chk("R8 s_addr", 64'(s_addr[2*AW +: AW]), 64'(m_addr[4*AW +: AW]));
      chk("R8 s_wdata", s_wdata[2*DW +: DW], m_wdata[4*DW +: DW]);
      chk("R8 s_we", 64'(s_we[2]), 64'(m_we[4]));
      chk("R8 s_last", 64'(s_last[2]), 64'h1);
      chk("R7 owner rdata", m_rdata[4*DW +: DW], s_rdata[2*DW +: DW]);
      chk("R7 loser rdata", m_rdata[2*DW +: DW], 64'h0);
      chk("R7 m_ready", 64'(m_ready), 64'b10000);

      // R7: slave not ready gives no ready even to owner.
      drive(5'b00100, 10'h020, 5'b11111, 4'b1011);
      chk("R7 not ready", 64'(m_ready), 64'h0);
      chk("R7 owner rdata no ready", m_rdata[2*DW +: DW], s_rdata[2*DW +: DW]);
      drive(5'b00100, 10'h020, 5'b11111, 4'b0100);
      chk("R5 complete", 64'(m_ready), 64'b00100);

      // Reset in the middle of a held transfer restarts rotation at master 0.
      drive(5'b01000, 10'h040, 5'b00000, 4'b0010);
      chk("R4 m3 owns slave 1", 64'(m_ready), 64'b01000);
      @(negedge clk);
      m_req = '0;
      rst_n = 1'b0;
      #1;
      chk("R2 reset mid transfer", 64'(s_req), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(5'b01001, 10'h041, 5'b11111, 4'b0010);
      chk("R3 post reset m0 first", 64'(m_ready), 64'b00001);
      drive(5'b01001, 10'h041, 5'b11111, 4'b0010);
      chk("R3 then m3", 64'(m_ready), 64'b01000);
      drive(5'b00000, 10'h000, 5'b00000, 4'b0000);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule